// File: doc/BRIEF.md
# Receive Character Queue with Error Status

This block holds received characters between the serial receive shifter and the host. The queue has three entries. Each entry stores an 8-bit character and three flags: parity error (also used as the address/data marker), framing error and break. The write side takes one assembled character per cycle over a valid/ready handshake. The read side shows the head character together with its status. A host data read pops the head entry. Looking at the status outputs never changes the queue.

Error status can be shown in two ways. In per-character mode the status outputs show the flags of the head entry. In block mode they show a sticky OR of the flags of every entry that has reached the head since the last clear-errors pulse. A write that arrives while the queue is full is discarded and sets a sticky overrun flag.

A receiver-reset pulse realigns the read pointer to the write pointer and empties the queue, but leaves the stored characters in place. A read of an empty queue still moves the read pointer, so stale characters can come back later. An optional automatic flow control drops request-to-send when a start bit is detected while the queue is full. It raises request-to-send again once an entry is freed.

Write-side rules: `wr_ready` is high whenever the queue is not full, or when a pop happens in the same cycle. A beat with `wr_valid` high and `wr_ready` low is dropped and counts as an overrun, because the shifter cannot wait. Read-side rules: `rd_valid` is the not-empty flag. Each cycle with `rd_ready` high pops one entry at the clock edge, whether `rd_valid` is high or not.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to 3 entries. Each entry is a character plus its three flags. Entries leave in the order they were accepted, and `rd_data` shows the head character.
- R2: `rd_valid` is high when at least one entry is stored. `full` is high when 3 entries are stored. `wr_ready` is high when the queue is not full or `rd_ready` is high.
- R3: A cycle with `rd_ready` high pops the head at the clock edge. Cycles with `rd_ready` and `wr_valid` low change neither `rd_data`, `rd_valid` nor `full`, so reading status never pops.
- R4: With `blk_mode` low, the status outputs show the flags of the head entry, and they are all zero while the queue is empty.
- R5: With `blk_mode` high, the status outputs show the OR of the flags of every entry that has become head since the last `rst_err` pulse. An entry that is not yet at the head does not contribute.
- R6: A `rx_reset` pulse empties the queue from the next cycle and sets the read pointer equal to the write pointer. Stored characters are not erased and can be returned after a later misaligned read.
- R7: A pop of an empty queue still advances the read pointer. A later write then leaves an older stored entry at the head.
- R8: With `auto_rts_en` high, a `start_det` pulse while the queue is full drives `rts_n` high. `rts_n` goes low again in the cycle after a pop frees an entry. In all other cases `rts_n` is the inverse of `rts_req`.
- R9: A write beat offered while `wr_ready` is low is discarded and sets `overrun`. `overrun` stays set until a `rst_err` pulse clears it.
- R10: The status flags of a newly written head entry appear in the same cycle that `rd_valid` first shows the entry.
- R11: After `rst_n` is released, `rd_valid`, `full`, `overrun` and all status outputs are low, and `rts_n` is the inverse of `rts_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Shifter offers a completed character |
| wr_ready | output | 1 | Queue can accept the offered character |
| wr_data | input | 8 | Received character |
| wr_par_err | input | 1 | Parity error or address/data marker of the character |
| wr_frm_err | input | 1 | Framing error of the character |
| wr_brk | input | 1 | Break received with the character |
| rd_valid | output | 1 | Queue not empty |
| rd_ready | input | 1 | Host data read; pops the head at the clock edge |
| rd_data | output | 8 | Head character |
| st_par_err | output | 1 | Parity status (head or accumulated) |
| st_frm_err | output | 1 | Framing status (head or accumulated) |
| st_brk | output | 1 | Break status (head or accumulated) |
| full | output | 1 | All entries occupied |
| overrun | output | 1 | Sticky lost-character flag |
| blk_mode | input | 1 | 0: per-character status, 1: accumulated status |
| rst_err | input | 1 | Clear-errors pulse |
| rx_reset | input | 1 | Receiver-reset pulse |
| start_det | input | 1 | Valid start bit detected by the shifter |
| auto_rts_en | input | 1 | Enable automatic request-to-send control |
| rts_req | input | 1 | Host request-to-send level |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The bench builds the block with its defaults: three entries of eight bits. A non-power-of-two depth makes the read and write pointers wrap at slot 2, and a few writes reach that wrap. Because the depth is only 3, a short sequence can fill the queue, overrun it, drop request-to-send, and walk the pointers out of alignment with empty reads. The bench can then show that a realigning reset keeps old characters intact. Block-mode accumulation is checked while a flagged entry waits behind the head, so the test separates "stored" from "reached the head".

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic par;
    logic frm;
    logic brk;
  } rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [PTR_W-1:0]              waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  rxq_flags_t                    wflags,
  output logic [DEPTH-1:0][DATA_W-1:0]  data_all,
  output rxq_flags_t [DEPTH-1:0]        flags_all
);
  // One register set per slot; contents change only on an accepted write
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_all[g]  <= '0;
        flags_all[g] <= '0;
      end else if (we && (waddr == PTR_W'(g))) begin
        data_all[g]  <= wdata;
        flags_all[g] <= wflags;
      end
    end
  end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int DEPTH = 3,
  parameter int PTR_W = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             rd_ready,
  input  logic             rx_reset,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] nxt_rd_ptr,
  output logic             head_arrive,
  output logic             we,
  output logic             ovf,
  output logic             full,
  output logic             not_empty,
  output logic             wr_ready
);
  logic [CNT_W-1:0] count, nxt_cnt;
  logic [PTR_W-1:0] nxt_wr_ptr;
  logic             pop;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign not_empty = (count != '0);
  assign wr_ready  = !full || rd_ready;
  assign we        = wr_valid && wr_ready && !rx_reset;
  assign ovf       = wr_valid && !wr_ready && !rx_reset;
  assign pop       = rd_ready && !rx_reset;

  always_comb begin
    nxt_wr_ptr = we ? step_ptr(wr_ptr) : wr_ptr;
    if (rx_reset) begin
      nxt_rd_ptr = wr_ptr;
      nxt_cnt    = '0;
    end else begin
      nxt_rd_ptr = pop ? step_ptr(rd_ptr) : rd_ptr;
      nxt_cnt    = count + CNT_W'(we) - CNT_W'(pop && not_empty);
    end
    // A new entry becomes head when the queue was empty or the head leaves
    head_arrive = !rx_reset && (nxt_cnt != '0) && (!not_empty || pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= nxt_wr_ptr;
      rd_ptr <= nxt_rd_ptr;
      count  <= nxt_cnt;
    end
  end
endmodule

// File: rtl/rxq_errs.sv
module rxq_errs
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int PTR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   blk_mode,
  input  logic                   rst_err,
  input  logic                   ovf,
  input  logic                   not_empty,
  input  logic [PTR_W-1:0]       rd_ptr,
  input  logic [PTR_W-1:0]       nxt_rd_ptr,
  input  logic [PTR_W-1:0]       wr_ptr,
  input  logic                   head_arrive,
  input  logic                   we,
  input  rxq_flags_t             wflags,
  input  rxq_flags_t [DEPTH-1:0] flags_all,
  output rxq_flags_t             stat,
  output logic                   overrun
);
  rxq_flags_t acc, arr_flags, head_flags;

  // Flags of the entry that will sit at the head after this edge
  always_comb begin
    if (we && (wr_ptr == nxt_rd_ptr)) arr_flags = wflags;
    else                              arr_flags = flags_all[nxt_rd_ptr];
    head_flags = not_empty ? flags_all[rd_ptr] : '0;
    stat       = blk_mode ? acc : head_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      overrun <= 1'b0;
    end else begin
      acc     <= (rst_err ? rxq_flags_t'('0) : acc) |
                 (head_arrive ? arr_flags : rxq_flags_t'('0));
      overrun <= ovf ? 1'b1 : (rst_err ? 1'b0 : overrun);
    end
  end
endmodule

// File: rtl/rxq_rts.sv
module rxq_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic start_det,
  input  logic full,
  input  logic pop_free,
  input  logic rx_reset,
  input  logic rts_req,
  output logic rts_n
);
  logic hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= auto_en && !rx_reset && !pop_free &&
                        (hold || (start_det && full));
  end

  assign rts_n = !rts_req || hold;
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par_err,
  input  logic              wr_frm_err,
  input  logic              wr_brk,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              st_par_err,
  output logic              st_frm_err,
  output logic              st_brk,
  output logic              full,
  output logic              overrun,
  input  logic              blk_mode,
  input  logic              rst_err,
  input  logic              rx_reset,
  input  logic              start_det,
  input  logic              auto_rts_en,
  input  logic              rts_req,
  output logic              rts_n
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]             wr_ptr, rd_ptr, nxt_rd_ptr;
  logic                         head_arrive, we, ovf;
  logic [DEPTH-1:0][DATA_W-1:0] data_all;
  rxq_flags_t [DEPTH-1:0]       flags_all;
  rxq_flags_t                   wflags, stat;

  assign wflags = '{par: wr_par_err, frm: wr_frm_err, brk: wr_brk};

  rxq_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_ready(rd_ready),
    .rx_reset(rx_reset), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .nxt_rd_ptr(nxt_rd_ptr), .head_arrive(head_arrive), .we(we), .ovf(ovf),
    .full(full), .not_empty(rd_valid), .wr_ready(wr_ready)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(wr_ptr), .wdata(wr_data),
    .wflags(wflags), .data_all(data_all), .flags_all(flags_all)
  );

  rxq_errs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_errs (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .rst_err(rst_err),
    .ovf(ovf), .not_empty(rd_valid), .rd_ptr(rd_ptr), .nxt_rd_ptr(nxt_rd_ptr),
    .wr_ptr(wr_ptr), .head_arrive(head_arrive), .we(we), .wflags(wflags),
    .flags_all(flags_all), .stat(stat), .overrun(overrun)
  );

  rxq_rts u_rts (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .start_det(start_det),
    .full(full), .pop_free(rd_ready && rd_valid), .rx_reset(rx_reset),
    .rts_req(rts_req), .rts_n(rts_n)
  );

  assign rd_data    = data_all[rd_ptr];
  assign st_par_err = stat.par;
  assign st_frm_err = stat.frm;
  assign st_brk     = stat.brk;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              st_par_err,
  input logic              st_frm_err,
  input logic              st_brk,
  input logic              full,
  input logic              overrun,
  input logic              blk_mode,
  input logic              rst_err,
  input logic              rx_reset,
  input logic              start_det,
  input logic              auto_rts_en,
  input logic              rts_n
);
  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> rd_valid); // R2
  AST_NOT_FULL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> wr_ready); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ready && !wr_valid && !rx_reset) |=> ($stable(rd_data) && $stable(rd_valid) && $stable(full))); // R3
  AST_POP_LEAVES_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !wr_valid && !rx_reset) |=> !full); // R3
  AST_CHAR_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_mode && !rd_valid) |-> (!st_par_err && !st_frm_err && !st_brk)); // R4
  AST_BLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && (st_par_err || st_frm_err || st_brk) && !rst_err) |=> (!blk_mode || st_par_err || st_frm_err || st_brk)); // R5
  AST_RXRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> !rd_valid); // R6
  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && start_det && full && !rd_ready && !rx_reset) |=> rts_n); // R8
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !rx_reset) |=> overrun); // R9
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rst_err) |=> overrun); // R9
endmodule

bind rxq_top rxq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .st_par_err(st_par_err), .st_frm_err(st_frm_err), .st_brk(st_brk),
  .full(full), .overrun(overrun), .blk_mode(blk_mode), .rst_err(rst_err),
  .rx_reset(rx_reset), .start_det(start_det), .auto_rts_en(auto_rts_en),
  .rts_n(rts_n)
);

// File: tb/rxq_top_tb.sv
module rxq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic       wr_par_err = 1'b0, wr_frm_err = 1'b0, wr_brk = 1'b0;
  logic       rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       st_par_err, st_frm_err, st_brk, full, overrun, rts_n;
  logic       blk_mode = 1'b0, rst_err = 1'b0, rx_reset = 1'b0;
  logic       start_det = 1'b0, auto_rts_en = 1'b0, rts_req = 1'b1;

  int  n_chk = 0;
  int  n_err = 0;
  bit  sb_on = 1'b1;
  bit  done  = 1'b0;
  logic [10:0] sbq[$];

  always #5 clk = ~clk;

  rxq_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err),
    .wr_brk(wr_brk), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .st_par_err(st_par_err), .st_frm_err(st_frm_err),
    .st_brk(st_brk), .full(full), .overrun(overrun), .blk_mode(blk_mode),
    .rst_err(rst_err), .rx_reset(rx_reset), .start_det(start_det),
    .auto_rts_en(auto_rts_en), .rts_req(rts_req), .rts_n(rts_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: offers one write beat; tracked beats go to the scoreboard
  task automatic push(input logic [7:0] d, input logic [2:0] f, input bit track);
    wr_valid = 1'b1;
    wr_data  = d;
    {wr_par_err, wr_frm_err, wr_brk} = f;
    if (track) sbq.push_back({d, f});
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic pop();
    rd_ready = 1'b1;
    @(posedge clk); #1;
    rd_ready = 1'b0;
  endtask

  task automatic pulse_err();
    rst_err = 1'b1; @(posedge clk); #1; rst_err = 1'b0;
  endtask

  task automatic pulse_rxrst();
    rx_reset = 1'b1; @(posedge clk); #1; rx_reset = 1'b0;
  endtask

  task automatic pulse_start();
    start_det = 1'b1; @(posedge clk); #1; start_det = 1'b0;
  endtask

  function automatic logic [2:0] st();
    return {st_par_err, st_frm_err, st_brk};
  endfunction

  // Monitor: each pop the design performs is compared with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && sb_on && rd_ready && rd_valid && !rx_reset) begin
      if (sbq.size() == 0) chk("R1 scoreboard underflow", 1, 0);
      else begin
        logic [10:0] e;
        e = sbq.pop_front();
        chk("R1 head data", 32'(rd_data), 32'(e[10:3]));
        if (!blk_mode) chk("R4 head flags", 32'(st()), 32'(e[2:0]));
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rd_valid", 32'(rd_valid), 0);
    chk("R11 full", 32'(full), 0);
    chk("R11 overrun", 32'(overrun), 0);
    chk("R11 status", 32'(st()), 0);
    chk("R11 rts_n", 32'(rts_n), 0);
    @(posedge clk); #1;

    // Character mode: flags encoded {par,frm,brk}
    push(8'h41, 3'b100, 1);
    @(negedge clk);
    chk("R10 valid with write", 32'(rd_valid), 1);
    chk("R10 flags with valid", 32'(st()), 32'(3'b100));
    @(posedge clk); #1;
    push(8'h42, 3'b010, 1);
    push(8'h43, 3'b001, 1);
    @(negedge clk);
    chk("R2 full", 32'(full), 1);
    chk("R2 wr_ready low", 32'(wr_ready), 0);
    chk("R4 head flags while deeper flagged", 32'(st()), 32'(3'b100));
    @(posedge clk); #1;
    push(8'h44, 3'b000, 0);
    @(negedge clk);
    chk("R9 overrun set", 32'(overrun), 1);
    chk("R9 still full", 32'(full), 1);
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    chk("R3 status read keeps head", 32'(rd_data), 32'h41);
    chk("R3 status read keeps full", 32'(full), 1);
    chk("R9 overrun sticky", 32'(overrun), 1);
    @(posedge clk); #1;
    pop(); pop(); pop();
    @(negedge clk);
    chk("R2 empty after pops", 32'(rd_valid), 0);
    chk("R4 empty status zero", 32'(st()), 0);
    chk("R1 dropped beat absent", 32'(sbq.size()), 0);
    @(posedge clk); #1;
    pulse_err();
    @(negedge clk);
    chk("R9 overrun cleared", 32'(overrun), 0);
    @(posedge clk); #1;

    // Block mode accumulation
    blk_mode = 1'b1;
    pulse_err();
    push(8'h45, 3'b100, 1);
    @(negedge clk);
    chk("R10 block status with valid", 32'(st()), 32'(3'b100));
    @(posedge clk); #1;
    push(8'h46, 3'b010, 1);
    @(negedge clk);
    chk("R5 waiting entry not counted", 32'(st()), 32'(3'b100));
    @(posedge clk); #1;
    pop();
    @(negedge clk);
    chk("R5 head arrival ORed", 32'(st()), 32'(3'b110));
    @(posedge clk); #1;
    pop();
    @(negedge clk);
    chk("R5 sticky when empty", 32'(st()), 32'(3'b110));
    @(posedge clk); #1;
    pulse_err();
    @(negedge clk);
    chk("R5 cleared by rst_err", 32'(st()), 0);
    @(posedge clk); #1;
    blk_mode = 1'b0;

    // Pointer misalignment and realignment (slot W is wherever rx_reset leaves it)
    sb_on = 1'b0;
    pulse_rxrst();
    push(8'h51, 3'b000, 0);
    push(8'h52, 3'b001, 0);
    push(8'h53, 3'b000, 0);
    pop(); pop(); pop();
    pop();                          // empty read moves read pointer
    push(8'h54, 3'b010, 0);
    @(negedge clk);
    chk("R7 stale head data", 32'(rd_data), 32'h52);
    chk("R7 stale head flags", 32'(st()), 32'(3'b001));
    @(posedge clk); #1;
    pulse_rxrst();
    @(negedge clk);
    chk("R6 empty after rx_reset", 32'(rd_valid), 0);
    @(posedge clk); #1;
    push(8'h55, 3'b000, 0);
    @(negedge clk);
    chk("R6 aligned head", 32'(rd_data), 32'h55);
    @(posedge clk); #1;
    pop();
    pop();
    push(8'h56, 3'b000, 0);
    @(negedge clk);
    chk("R6 storage survived rx_reset", 32'(rd_data), 32'h54);
    chk("R6 survived flags", 32'(st()), 32'(3'b010));
    @(posedge clk); #1;
    pulse_rxrst();
    sb_on = 1'b1;

    // Automatic request-to-send
    auto_rts_en = 1'b1;
    pulse_start();
    @(negedge clk);
    chk("R8 start when not full", 32'(rts_n), 0);
    @(posedge clk); #1;
    push(8'h61, 3'b000, 1);
    push(8'h62, 3'b000, 1);
    push(8'h63, 3'b000, 1);
    @(negedge clk);
    chk("R8 full without start", 32'(rts_n), 0);
    @(posedge clk); #1;
    pulse_start();
    @(negedge clk);
    chk("R8 dropped on start while full", 32'(rts_n), 1);
    @(posedge clk); #1;
    pop();
    @(negedge clk);
    chk("R8 restored after pop", 32'(rts_n), 0);
    @(posedge clk); #1;
    pop(); pop();
    @(negedge clk);
    chk("R1 scoreboard drained", 32'(sbq.size()), 0);
    rts_req = 1'b0;
    #1;
    chk("R8 follows rts_req", 32'(rts_n), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule